// File: doc/BRIEF.md
# LED Matrix Scan and Blink Timer

This block produces the refresh timing for an eight-digit display built from 5-column by 7-row LED dot matrices. The fourteen physical rows are driven as two groups of seven: the first group lights digits 0 to 3 and the second lights digits 4 to 7. Each display cycle shows one row, with twenty column bits (four digits of five columns each). Fourteen display cycles make one frame that refreshes every digit.

The timing comes from one of two tick sources, chosen by a select input. One is the local oscillator tick and the other is a tick from another display, so that several displays can blink in step. Both sources arrive as single-cycle enable pulses on the system clock. The ticks feed a divide chain. A tick divider paces the display cycles, a row sequencer steps through the fourteen rows, and a frame counter sets the blink period.

While one row is lit, the block presents the group and row-within-group of the next row on a fetch address, so that an external font lookup can answer. The answering 20-bit column word is latched in the same cycle that the row index advances, so a row is never lit with the previous row's columns. During the off half of the blink, the five columns of any digit whose flash bit is set are forced to zero.

Top module: `matrix_scan_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `row_idx_o` is 0, `cols_o` is 0, `col_strobe_o` is 0 and `blink_off_o` is 0.
- R2: When `clk_sel` is 1, only `osc_tick` pulses count as ticks. When it is 0, only `ext_tick` pulses count. Pulses on the unselected input leave every output unchanged.
- R3: The display advances by one row once every `TICK_DIV` counted ticks. The advance is marked by `col_strobe_o` being high for exactly one cycle, in the cycle after the edge that takes the final tick.
- R4: `row_idx_o` steps 0, 1, … , 13 and then wraps to 0. Rows 0–6 form group 0 (digits 0–3) and rows 7–13 form group 1 (digits 4–7).
- R5: `fetch_grp_o` and `fetch_row_o` give the group and the row-within-group (0–6) of the row that follows the one currently shown in `row_idx_o`.
- R6: In the cycle where `col_strobe_o` is high, `row_idx_o` shows the new row and `cols_o` holds the `font_cols_i` word that was present at the fetch address when the advance happened. Digit slot j of the group occupies bits 5j+4 down to 5j.
- R7: `blink_off_o` is 0 for `BLINK_DIV/2` frames and then 1 for `BLINK_DIV/2` frames, giving a 50% duty cycle. It changes only when the row wraps from 13 to 0.
- R8: When a row is latched during the off phase (including the latch that begins the off phase), the slot of every digit d = 4·group + j with `flash_i[d]` = 1 is zero in `cols_o`. During the on phase, `flash_i` has no effect.
- R9: A `cnt_clr` pulse acts on the next edge and takes precedence over any tick. It returns the row index, the divide chain and the blink phase to zero and clears `cols_o` and `col_strobe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1 selects the oscillator tick, 0 selects the external tick |
| osc_tick | input | 1 | Local oscillator tick, one-cycle pulse |
| ext_tick | input | 1 | Tick shared from another display, one-cycle pulse |
| cnt_clr | input | 1 | Synchronous clear of the counters and phase |
| flash_i | input | 8 | Per-digit flash enable, bit d for digit d |
| font_cols_i | input | 20 | Column word returned for the fetch address |
| fetch_grp_o | output | 1 | Group of the next row to be shown |
| fetch_row_o | output | 3 | Row within group of the next row |
| row_idx_o | output | 4 | Row currently lit, 0 to 13 |
| col_strobe_o | output | 1 | One-cycle pulse when a new row and its columns take effect |
| cols_o | output | 20 | Column drive for the lit row, after blanking |
| blink_off_o | output | 1 | 1 during the off half of the blink period |

## Verification
The assertions rely on two properties of the inputs. Both tick inputs must be clean single-cycle enables in the clock domain. The font word must settle, from the fetch address, within the same cycle. The bench keeps to both. It drives every input at the falling edge, produces ticks as level enables that are sampled once per edge, and derives `font_cols_i` from a fixed function of the fetch address. It also changes `flash_i` only between scenarios, so a slice check at a strobe refers to the flash bits present when the row was latched.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic {
        PHASE_ON  = 1'b0,
        PHASE_OFF = 1'b1
    } blink_phase_e;
endpackage

// File: rtl/scan_tick_div.sv
module scan_tick_div #(
    parameter int TICK_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic adv
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        adv  = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                adv      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scan_row_seq.sv
module scan_row_seq #(
    parameter int ROWS_PER_GRP = 7,
    parameter int GROUPS       = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            adv,
    output logic [$clog2(ROWS_PER_GRP)-1:0] row_q,
    output logic [$clog2(GROUPS)-1:0]       grp_q,
    output logic [$clog2(ROWS_PER_GRP)-1:0] row_nx,
    output logic [$clog2(GROUPS)-1:0]       grp_nx,
    output logic                            frame_wrap
);
    localparam int RW = $clog2(ROWS_PER_GRP);
    localparam int GW = $clog2(GROUPS);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS_PER_GRP - 1);
    localparam logic [GW-1:0] GRP_LAST = GW'(GROUPS - 1);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [GW-1:0] grp;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        row_nx = st_q.row + 1'b1;
        grp_nx = st_q.grp;
        if (st_q.row == ROW_LAST) begin
            row_nx = '0;
            grp_nx = (st_q.grp == GRP_LAST) ? '0 : st_q.grp + 1'b1;
        end
        frame_wrap = adv && !clr && (st_q.row == ROW_LAST) && (st_q.grp == GRP_LAST);

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (adv) begin
            st_d.row = row_nx;
            st_d.grp = grp_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_q = st_q.row;
    assign grp_q = st_q.grp;
endmodule

// File: rtl/scan_blink_div.sv
module scan_blink_div
    import scan_pkg::*;
#(
    parameter int BLINK_DIV = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         frame_wrap,
    output blink_phase_e phase_q,
    output blink_phase_e phase_d
);
    localparam int BW = $clog2(BLINK_DIV);

    typedef struct packed {
        logic [BW-1:0] frames;
    } blink_state_t;

    blink_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)             st_d.frames = '0;
        else if (frame_wrap) st_d.frames = st_q.frames + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_q = blink_phase_e'(st_q.frames[BW-1]);
    assign phase_d = blink_phase_e'(st_d.frames[BW-1]);
endmodule

// File: rtl/scan_col_mask.sv
module scan_col_mask #(
    parameter int DIGITS_PER_GRP = 4,
    parameter int COLS_PER_DIGIT = 5,
    parameter int GROUPS         = 2
) (
    input  logic [DIGITS_PER_GRP*COLS_PER_DIGIT-1:0] cols_in,
    input  logic [$clog2(GROUPS)-1:0]                grp,
    input  logic                                     blank,
    input  logic [GROUPS*DIGITS_PER_GRP-1:0]         flash,
    output logic [DIGITS_PER_GRP*COLS_PER_DIGIT-1:0] cols_out
);
    localparam int DIGITS = GROUPS * DIGITS_PER_GRP;

    always_comb begin
        cols_out = cols_in;
        for (int j = 0; j < DIGITS_PER_GRP; j++) begin
            int dig;
            dig = int'(grp) * DIGITS_PER_GRP + j;
            if (blank && dig < DIGITS && flash[dig])
                cols_out[j*COLS_PER_DIGIT +: COLS_PER_DIGIT] = '0;
        end
    end
endmodule

// File: rtl/matrix_scan_timer.sv
module matrix_scan_timer
    import scan_pkg::*;
#(
    parameter int TICK_DIV       = 32,
    parameter int ROWS_PER_GRP   = 7,
    parameter int GROUPS         = 2,
    parameter int DIGITS_PER_GRP = 4,
    parameter int COLS_PER_DIGIT = 5,
    parameter int BLINK_DIV      = 128,
    localparam int RW     = $clog2(ROWS_PER_GRP),
    localparam int GW     = $clog2(GROUPS),
    localparam int ROW_W  = $clog2(ROWS_PER_GRP * GROUPS),
    localparam int COLS   = DIGITS_PER_GRP * COLS_PER_DIGIT,
    localparam int DIGITS = GROUPS * DIGITS_PER_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel,
    input  logic              osc_tick,
    input  logic              ext_tick,
    input  logic              cnt_clr,
    input  logic [DIGITS-1:0] flash_i,
    input  logic [COLS-1:0]   font_cols_i,
    output logic [GW-1:0]     fetch_grp_o,
    output logic [RW-1:0]     fetch_row_o,
    output logic [ROW_W-1:0]  row_idx_o,
    output logic              col_strobe_o,
    output logic [COLS-1:0]   cols_o,
    output logic              blink_off_o
);
    typedef struct packed {
        logic [COLS-1:0] cols;
        logic            strobe;
    } out_state_t;

    out_state_t   out_d, out_q;
    logic         tick, adv, frame_wrap;
    logic [RW-1:0] row_q, row_nx;
    logic [GW-1:0] grp_q, grp_nx;
    blink_phase_e phase_q, phase_d;
    logic [COLS-1:0] cols_masked;

    assign tick = clk_sel ? osc_tick : ext_tick;

    scan_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick), .adv(adv)
    );

    scan_row_seq #(.ROWS_PER_GRP(ROWS_PER_GRP), .GROUPS(GROUPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(adv),
        .row_q(row_q), .grp_q(grp_q), .row_nx(row_nx), .grp_nx(grp_nx),
        .frame_wrap(frame_wrap)
    );

    scan_blink_div #(.BLINK_DIV(BLINK_DIV)) u_blink (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .frame_wrap(frame_wrap),
        .phase_q(phase_q), .phase_d(phase_d)
    );

    scan_col_mask #(
        .DIGITS_PER_GRP(DIGITS_PER_GRP), .COLS_PER_DIGIT(COLS_PER_DIGIT), .GROUPS(GROUPS)
    ) u_mask (
        .cols_in(font_cols_i), .grp(grp_nx), .blank(phase_d == PHASE_OFF),
        .flash(flash_i), .cols_out(cols_masked)
    );

    always_comb begin
        out_d        = out_q;
        out_d.strobe = 1'b0;
        if (cnt_clr) begin
            out_d = '0;
        end else if (adv) begin
            out_d.cols   = cols_masked;
            out_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign fetch_grp_o  = grp_nx;
    assign fetch_row_o  = row_nx;
    assign row_idx_o    = ROW_W'(grp_q) * ROW_W'(ROWS_PER_GRP) + ROW_W'(row_q);
    assign col_strobe_o = out_q.strobe;
    assign cols_o       = out_q.cols;
    assign blink_off_o  = (phase_q == PHASE_OFF);
endmodule

// File: rtl/scan_timer_checker.sv
module scan_timer_checker #(
    parameter int ROWS_PER_GRP   = 7,
    parameter int GROUPS         = 2,
    parameter int DIGITS_PER_GRP = 4,
    parameter int COLS_PER_DIGIT = 5,
    parameter int ROW_W          = 4,
    parameter int COLS           = 20,
    parameter int DIGITS         = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic [DIGITS-1:0] flash_i,
    input logic [ROW_W-1:0]  row_idx_o,
    input logic              col_strobe_o,
    input logic [COLS-1:0]   cols_o,
    input logic              blink_off_o
);
    localparam int ROWS = ROWS_PER_GRP * GROUPS;
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx_o <= ROW_LAST);

    p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe_o |-> row_idx_o == (($past(row_idx_o) == ROW_LAST) ? '0 : $past(row_idx_o) + 1'b1));

    p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_strobe_o && !$past(cnt_clr)) |-> ($stable(row_idx_o) && $stable(cols_o)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (row_idx_o == '0 && !blink_off_o && cols_o == '0 && !col_strobe_o));

    p_blink_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blink_off_o) |-> ((col_strobe_o && row_idx_o == '0) || $past(cnt_clr)));

    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_blank
            p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (col_strobe_o && blink_off_o && (int'(row_idx_o) / ROWS_PER_GRP == d / DIGITS_PER_GRP)
                 && $past(flash_i[d]))
                |-> cols_o[(d % DIGITS_PER_GRP)*COLS_PER_DIGIT +: COLS_PER_DIGIT] == '0);
        end
    endgenerate
endmodule

bind matrix_scan_timer scan_timer_checker #(
    .ROWS_PER_GRP(ROWS_PER_GRP), .GROUPS(GROUPS), .DIGITS_PER_GRP(DIGITS_PER_GRP),
    .COLS_PER_DIGIT(COLS_PER_DIGIT), .ROW_W(ROW_W), .COLS(COLS), .DIGITS(DIGITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .flash_i(flash_i),
    .row_idx_o(row_idx_o), .col_strobe_o(col_strobe_o), .cols_o(cols_o),
    .blink_off_o(blink_off_o)
);

// File: tb/tb_matrix_scan_timer.sv
module tb_matrix_scan_timer;
    localparam int DIV = 4;
    localparam int RPG = 7;
    localparam int NG  = 2;
    localparam int DPG = 4;
    localparam int CPD = 5;
    localparam int BD  = 4;
    localparam int NROWS = RPG * NG;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_sel = 1'b1, osc_tick = 1'b0, ext_tick = 1'b0, cnt_clr = 1'b0;
    logic [7:0]  flash = 8'h00;
    logic [19:0] font;
    logic        fetch_grp;
    logic [2:0]  fetch_row;
    logic [3:0]  row_idx;
    logic        strobe;
    logic [19:0] cols;
    logic        blink_off;

    int errors = 0;
    int checks = 0;

    int m_div = 0, m_row = 0, m_frame = 0;
    logic        m_strobe = 1'b0;
    logic [19:0] m_cols = '0;

    always #2 clk = ~clk;

    function automatic logic [19:0] font_of(input logic g, input logic [2:0] r);
        return {g, r, ~r, g, r, 9'h15B};
    endfunction

    assign font = font_of(fetch_grp, fetch_row);

    matrix_scan_timer #(
        .TICK_DIV(DIV), .ROWS_PER_GRP(RPG), .GROUPS(NG),
        .DIGITS_PER_GRP(DPG), .COLS_PER_DIGIT(CPD), .BLINK_DIV(BD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .osc_tick(osc_tick),
        .ext_tick(ext_tick), .cnt_clr(cnt_clr), .flash_i(flash), .font_cols_i(font),
        .fetch_grp_o(fetch_grp), .fetch_row_o(fetch_row), .row_idx_o(row_idx),
        .col_strobe_o(strobe), .cols_o(cols), .blink_off_o(blink_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic m_phase();
        return m_frame >= BD / 2;
    endfunction

    function automatic logic [19:0] m_mask(input logic [19:0] c, input int g);
        logic [19:0] r;
        r = c;
        if (m_phase())
            for (int j = 0; j < DPG; j++)
                if (flash[g*DPG + j]) r[j*CPD +: CPD] = '0;
        return r;
    endfunction

    // one clock: drive at falling edge, update model at rising edge, compare after it
    task automatic cycle(input logic o, input logic e, input logic c);
        logic sel;
        int nr;
        logic [19:0] raw;
        @(negedge clk);
        osc_tick = o; ext_tick = e; cnt_clr = c;
        @(posedge clk);
        sel = clk_sel ? o : e;
        m_strobe = 1'b0;
        if (c) begin
            m_div = 0; m_row = 0; m_frame = 0; m_cols = '0;
        end else if (sel) begin
            if (m_div == DIV - 1) begin
                m_div = 0;
                nr = (m_row + 1) % NROWS;
                raw = font_of(1'(nr / RPG), 3'(nr % RPG));
                if (nr == 0) m_frame = (m_frame + 1) % BD;
                m_row = nr;
                m_cols = m_mask(raw, nr / RPG);
                m_strobe = 1'b1;
            end else begin
                m_div++;
            end
        end
        #1;
        check("R4 row_idx", 32'(row_idx), 32'(m_row));
        check("R3 strobe", 32'(strobe), 32'(m_strobe));
        check("R5 fetch", {28'd0, fetch_grp, fetch_row},
              {28'd0, 1'((m_row + 1) % NROWS / RPG), 3'((m_row + 1) % NROWS % RPG)});
        if (m_phase() && ((flash >> ((m_row / RPG) * DPG)) & 8'h0F) != 0)
            check("R8 cols", 32'(cols), 32'(m_cols));
        else
            check("R6 cols", 32'(cols), 32'(m_cols));
        check("R7 blink", 32'(blink_off), 32'(m_phase()));
    endtask

    task automatic test_reset();
        #1;
        check("R1 reset row", 32'(row_idx), 0);
        check("R1 reset cols", 32'(cols), 0);
        check("R1 reset strobe", 32'(strobe), 0);
        check("R1 reset blink", 32'(blink_off), 0);
        @(negedge clk); rst_n = 1'b1;
        cycle(0, 0, 0);
    endtask

    task automatic test_source_osc();
        clk_sel = 1'b1;
        for (int i = 0; i < 30; i++) cycle(0, 1, 0);   // R2: unselected external ticks
        check("R2 ext ignored row", 32'(row_idx), 0);
        for (int i = 0; i < 40; i++) cycle(1, 0, 0);
        for (int i = 0; i < 40; i++) cycle(i % 3 == 0, 1, 0);
    endtask

    task automatic test_source_ext();
        int r0;
        clk_sel = 1'b0;
        r0 = m_row;
        for (int i = 0; i < 30; i++) cycle(1, 0, 0);   // R2: unselected oscillator ticks
        check("R2 osc ignored row", 32'(row_idx), 32'(r0));
        for (int i = 0; i < 60; i++) cycle(0, 1, 0);
        clk_sel = 1'b1;
    endtask

    task automatic test_blink();
        int seen_off;
        seen_off = 0;
        flash = 8'b1010_0110;
        for (int i = 0; i < 2 * NROWS * DIV * BD + 20; i++) begin
            cycle(1, 0, 0);
            if (blink_off) seen_off++;
        end
        check("R7 off phase seen", 32'(seen_off > 0), 1);
        flash = 8'hFF;
        for (int i = 0; i < NROWS * DIV * BD; i++) cycle(1, 0, 0);
        flash = 8'h00;
    endtask

    task automatic test_clear();
        for (int i = 0; i < 37; i++) cycle(1, 0, 0);
        cycle(1, 0, 1);
        check("R9 clear row", 32'(row_idx), 0);
        check("R9 clear cols", 32'(cols), 0);
        for (int i = 0; i < DIV - 1; i++) cycle(1, 0, 0);
        check("R9 divider restarted", 32'(strobe), 0);
        cycle(1, 0, 0);
        check("R9 first advance after clear", 32'(strobe), 1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_source_osc();
        test_source_ext();
        test_blink();
        test_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule